// File: doc/BRIEF.md
# Multi-Block Trace Cache: Lookup and Fill

This block is a small direct-mapped cache for dynamic instruction sequences. It sits next to the instruction cache. Each line holds a run of up to eight instructions in the order they retired. The run may cross up to three basic blocks, so one access can return instructions that follow one or more taken branches. Lookup takes a fetch address and a vector of branch predictions. One cycle later the block presents a registered fetch packet: either the whole stored trace (a hit) or the single instruction offered by the instruction-cache path (a miss). The packet also carries the address to fetch next.

A fill buffer builds new traces from instructions as they retire. It appends instructions one by one and keeps the outcome of every branch it sees. When the trace reaches its instruction limit or its branch limit, it writes the finished line into the set that the trace's first address selects. A line stores a valid bit, a tag, the recorded branch directions, a mask of which directions are meaningful, the address after the last instruction, the target of a closing branch, the instruction count and the instructions.

Addresses are split into a set index (low bits) and a tag (the remaining upper bits). Prediction bit i and recorded direction bit i both refer to the i-th branch of the trace, counted in program order from bit 0. Instructions are packed in the packet with slot i at bits [i*16 +: 16].

Top module: `trace_cache_fetch`

## Requirements
- R1: While reset is held, `out_valid` is 0. Reset invalidates every line, so any lookup made after reset misses.
- R2: A lookup hits when all three hold: the line in the indexed set is valid, its tag equals the upper address bits, and every prediction bit under the line's mask equals the recorded direction. On a hit, the packet that appears one cycle later has `out_hit`=1, `out_count` equal to the stored count, and every stored instruction in its slot.
- R3: Prediction bits at positions beyond the number of branches recorded in the line have no effect on the hit decision.
- R4: A lookup misses if any prediction bit under the mask differs from the recorded direction.
- R5: A lookup misses if the indexed line holds a different tag, even when the index matches.
- R6: On a miss, the packet has `out_hit`=0 and `out_count`=1. Slot 0 holds `ic_insn`, and `out_next` is the lookup address plus one.
- R7: The fill buffer closes a trace and writes it when the eighth instruction arrives. If that trace has fewer than three branches, its mask covers only the branches it recorded.
- R8: The fill buffer closes a trace and writes it when the third branch arrives. The branch directions are recorded in program order from bit 0.
- R9: On a hit, `out_next` is the stored target when the line records at least one branch and the prediction for the last recorded branch is taken. Otherwise `out_next` is the stored fall-through address. The fall-through is the address of the last instruction plus one. The target is the closing branch's target if the trace ends on a branch, and the fall-through otherwise.
- R10: A lookup in the same cycle as a write to its set sees the old line contents. The next cycle sees the new line.
- R11: Packet slots at or beyond `out_count` read as zero.
- R12: `out_valid` in a cycle equals `lk_valid` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 16 | Fetch address of the lookup |
| lk_pred | input | 3 | Branch predictions, bit i for the i-th branch |
| ic_insn | input | 16 | Instruction from the instruction-cache path, used on a miss |
| fl_valid | input | 1 | A retiring instruction is offered to the fill buffer |
| fl_pc | input | 16 | Address of the retiring instruction |
| fl_insn | input | 16 | Retiring instruction word |
| fl_is_br | input | 1 | Retiring instruction is a conditional branch |
| fl_taken | input | 1 | Resolved direction of that branch |
| fl_target | input | 16 | Taken target of that branch |
| out_valid | output | 1 | Fetch packet valid |
| out_hit | output | 1 | Packet comes from the trace array (1) or the instruction-cache path (0) |
| out_count | output | 4 | Number of instructions in the packet |
| out_insns | output | 128 | Packet instructions, slot i at bits [i*16 +: 16] |
| out_next | output | 16 | Next fetch address |

## Verification
The bench fills traces that end in each of the two ways, one by the branch limit and one by the instruction limit. It then probes them with predictions that agree, that disagree on a masked branch, and that differ only in unmasked bits. A hit check that ignored the mask would miss on the instruction-limited trace. A check that masked too much would hit on a mispredicted branch. Lines with no branches, with a taken last branch and with a not-taken last branch each test the next-address choice, which catches a selector that uses the wrong branch or the wrong address. A fill and a lookup to the same set in one cycle must return the old trace, which catches a write forwarded into the read path. The bench also clears zero tail slots on a miss and re-applies reset to confirm that lines are invalidated.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    SRC_ICACHE = 1'b0,
    SRC_TRACE  = 1'b1
  } tc_src_e;
endpackage

// File: rtl/tc_fill_buffer.sv
module tc_fill_buffer #(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int N_INSN = 8,
  parameter int M_BLK  = 3,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(N_INSN + 1),
  localparam int BLK_W = $clog2(M_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fl_valid,
  input  logic [ADDR_W-1:0]        fl_pc,
  input  logic [INSN_W-1:0]        fl_insn,
  input  logic                     fl_is_br,
  input  logic                     fl_taken,
  input  logic [ADDR_W-1:0]        fl_target,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_idx,
  output logic [TAG_W-1:0]         wr_tag,
  output logic [M_BLK-1:0]         wr_flags,
  output logic [M_BLK-1:0]         wr_mask,
  output logic [ADDR_W-1:0]        wr_ft,
  output logic [ADDR_W-1:0]        wr_tgt,
  output logic [CNT_W-1:0]         wr_cnt,
  output logic [N_INSN*INSN_W-1:0] wr_insns
);

  logic [CNT_W-1:0]         cnt_q, cnt_d, cnt_inc;
  logic [BLK_W-1:0]         blk_q, blk_d, blk_inc;
  logic [M_BLK-1:0]         flags_q, flags_d, flags_new;
  logic [ADDR_W-1:0]        start_q, start_d, head_pc;
  logic [N_INSN*INSN_W-1:0] insns_q, insns_d, insns_new;
  logic                     done;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    blk_inc = blk_q + BLK_W'(fl_is_br);
    head_pc = (cnt_q == '0) ? fl_pc : start_q;
    flags_new = flags_q;
    for (int i = 0; i < M_BLK; i++) begin
      if (fl_is_br && (blk_q == BLK_W'(i))) flags_new[i] = fl_taken;
    end
    insns_new = insns_q;
    for (int i = 0; i < N_INSN; i++) begin
      if (cnt_q == CNT_W'(i)) insns_new[i*INSN_W +: INSN_W] = fl_insn;
    end
    done = fl_valid && ((cnt_inc == CNT_W'(N_INSN)) ||
                        (fl_is_br && (blk_inc == BLK_W'(M_BLK))));

    cnt_d   = cnt_q;
    blk_d   = blk_q;
    flags_d = flags_q;
    start_d = start_q;
    insns_d = insns_q;
    if (fl_valid) begin
      if (done) begin
        cnt_d   = '0;
        blk_d   = '0;
        flags_d = '0;
      end else begin
        cnt_d   = cnt_inc;
        blk_d   = blk_inc;
        flags_d = flags_new;
        start_d = head_pc;
        insns_d = insns_new;
      end
    end

    wr_en    = done;
    wr_idx   = head_pc[IDX_W-1:0];
    wr_tag   = head_pc[ADDR_W-1:IDX_W];
    wr_flags = flags_new;
    for (int i = 0; i < M_BLK; i++) wr_mask[i] = (BLK_W'(i) < blk_inc);
    wr_ft    = fl_pc + 1'b1;
    wr_tgt   = fl_is_br ? fl_target : (fl_pc + 1'b1);
    wr_cnt   = cnt_inc;
    wr_insns = insns_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blk_q   <= '0;
      flags_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      blk_q   <= blk_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_valid) begin
      start_q <= start_d;
      insns_q <= insns_d;
    end
  end

endmodule

// File: rtl/tc_array.sv
module tc_array #(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int N_INSN = 8,
  parameter int M_BLK  = 3,
  parameter int IDX_W  = 3,
  localparam int SETS  = 1 << IDX_W,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(N_INSN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [M_BLK-1:0]         wr_flags,
  input  logic [M_BLK-1:0]         wr_mask,
  input  logic [ADDR_W-1:0]        wr_ft,
  input  logic [ADDR_W-1:0]        wr_tgt,
  input  logic [CNT_W-1:0]         wr_cnt,
  input  logic [N_INSN*INSN_W-1:0] wr_insns,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [M_BLK-1:0]         rd_flags,
  output logic [M_BLK-1:0]         rd_mask,
  output logic [ADDR_W-1:0]        rd_ft,
  output logic [ADDR_W-1:0]        rd_tgt,
  output logic [CNT_W-1:0]         rd_cnt,
  output logic [N_INSN*INSN_W-1:0] rd_insns
);

  logic [SETS-1:0]          valid_q;
  logic [TAG_W-1:0]         tag_q   [SETS];
  logic [M_BLK-1:0]         flags_q [SETS];
  logic [M_BLK-1:0]         mask_q  [SETS];
  logic [ADDR_W-1:0]        ft_q    [SETS];
  logic [ADDR_W-1:0]        tgt_q   [SETS];
  logic [CNT_W-1:0]         cnt_q   [SETS];
  logic [N_INSN*INSN_W-1:0] insns_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_we;
    assign set_we = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q[s] <= 1'b0;
      else if (set_we) valid_q[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (set_we) begin
        tag_q[s]   <= wr_tag;
        flags_q[s] <= wr_flags;
        mask_q[s]  <= wr_mask;
        ft_q[s]    <= wr_ft;
        tgt_q[s]   <= wr_tgt;
        cnt_q[s]   <= wr_cnt;
        insns_q[s] <= wr_insns;
      end
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_flags = flags_q[rd_idx];
    rd_mask  = mask_q[rd_idx];
    rd_ft    = ft_q[rd_idx];
    rd_tgt   = tgt_q[rd_idx];
    rd_cnt   = cnt_q[rd_idx];
    rd_insns = insns_q[rd_idx];
  end

endmodule

// File: rtl/tc_hit_select.sv
module tc_hit_select
  import tc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int N_INSN = 8,
  parameter int M_BLK  = 3,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(N_INSN + 1)
) (
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [M_BLK-1:0]         lk_pred,
  input  logic [INSN_W-1:0]        ic_insn,
  input  logic                     rd_valid,
  input  logic [TAG_W-1:0]         rd_tag,
  input  logic [M_BLK-1:0]         rd_flags,
  input  logic [M_BLK-1:0]         rd_mask,
  input  logic [ADDR_W-1:0]        rd_ft,
  input  logic [ADDR_W-1:0]        rd_tgt,
  input  logic [CNT_W-1:0]         rd_cnt,
  input  logic [N_INSN*INSN_W-1:0] rd_insns,
  output logic                     hit,
  output logic [CNT_W-1:0]         sel_cnt,
  output logic [N_INSN*INSN_W-1:0] sel_insns,
  output logic [ADDR_W-1:0]        sel_next
);

  tc_src_e                  src;
  logic                     last_taken;
  logic [N_INSN*INSN_W-1:0] trace_insns;

  always_comb begin
    hit = rd_valid && (rd_tag == lk_addr[ADDR_W-1:IDX_W]) &&
          (((lk_pred ^ rd_flags) & rd_mask) == '0);
    src = hit ? SRC_TRACE : SRC_ICACHE;

    last_taken = 1'b0;
    for (int i = 0; i < M_BLK; i++) begin
      if (rd_mask[i]) last_taken = lk_pred[i];
    end

    for (int i = 0; i < N_INSN; i++) begin
      trace_insns[i*INSN_W +: INSN_W] =
        (CNT_W'(i) < rd_cnt) ? rd_insns[i*INSN_W +: INSN_W] : '0;
    end

    case (src)
      SRC_TRACE: begin
        sel_cnt   = rd_cnt;
        sel_insns = trace_insns;
        sel_next  = last_taken ? rd_tgt : rd_ft;
      end
      default: begin
        sel_cnt   = CNT_W'(1);
        sel_insns = '0;
        sel_insns[INSN_W-1:0] = ic_insn;
        sel_next  = lk_addr + 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/trace_cache_fetch.sv
module trace_cache_fetch #(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int N_INSN = 8,
  parameter int M_BLK  = 3,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(N_INSN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [M_BLK-1:0]         lk_pred,
  input  logic [INSN_W-1:0]        ic_insn,
  input  logic                     fl_valid,
  input  logic [ADDR_W-1:0]        fl_pc,
  input  logic [INSN_W-1:0]        fl_insn,
  input  logic                     fl_is_br,
  input  logic                     fl_taken,
  input  logic [ADDR_W-1:0]        fl_target,
  output logic                     out_valid,
  output logic                     out_hit,
  output logic [CNT_W-1:0]         out_count,
  output logic [N_INSN*INSN_W-1:0] out_insns,
  output logic [ADDR_W-1:0]        out_next
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [TAG_W-1:0]         wr_tag;
  logic [M_BLK-1:0]         wr_flags, wr_mask;
  logic [ADDR_W-1:0]        wr_ft, wr_tgt;
  logic [CNT_W-1:0]         wr_cnt;
  logic [N_INSN*INSN_W-1:0] wr_insns;

  logic                     rd_valid;
  logic [TAG_W-1:0]         rd_tag;
  logic [M_BLK-1:0]         rd_flags, rd_mask;
  logic [ADDR_W-1:0]        rd_ft, rd_tgt;
  logic [CNT_W-1:0]         rd_cnt;
  logic [N_INSN*INSN_W-1:0] rd_insns;

  logic                     hit_d;
  logic [CNT_W-1:0]         cnt_d;
  logic [N_INSN*INSN_W-1:0] insns_d;
  logic [ADDR_W-1:0]        next_d;

  tc_fill_buffer #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BLK(M_BLK), .IDX_W(IDX_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_sync_n),
    .fl_valid(fl_valid), .fl_pc(fl_pc), .fl_insn(fl_insn),
    .fl_is_br(fl_is_br), .fl_taken(fl_taken), .fl_target(fl_target),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_flags(wr_flags),
    .wr_mask(wr_mask), .wr_ft(wr_ft), .wr_tgt(wr_tgt), .wr_cnt(wr_cnt),
    .wr_insns(wr_insns)
  );

  tc_array #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BLK(M_BLK), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_flags(wr_flags),
    .wr_mask(wr_mask), .wr_ft(wr_ft), .wr_tgt(wr_tgt), .wr_cnt(wr_cnt),
    .wr_insns(wr_insns),
    .rd_idx(lk_addr[IDX_W-1:0]),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_flags(rd_flags), .rd_mask(rd_mask),
    .rd_ft(rd_ft), .rd_tgt(rd_tgt), .rd_cnt(rd_cnt), .rd_insns(rd_insns)
  );

  tc_hit_select #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BLK(M_BLK), .IDX_W(IDX_W)
  ) u_sel (
    .lk_addr(lk_addr), .lk_pred(lk_pred), .ic_insn(ic_insn),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_flags(rd_flags), .rd_mask(rd_mask),
    .rd_ft(rd_ft), .rd_tgt(rd_tgt), .rd_cnt(rd_cnt), .rd_insns(rd_insns),
    .hit(hit_d), .sel_cnt(cnt_d), .sel_insns(insns_d), .sel_next(next_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= lk_valid;
      if (lk_valid) out_hit <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      out_count <= cnt_d;
      out_insns <= insns_d;
      out_next  <= next_d;
    end
  end

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int N_INSN = 8,
  parameter int M_BLK  = 3,
  localparam int CNT_W = $clog2(N_INSN + 1)
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     lk_valid,
  input logic [ADDR_W-1:0]        lk_addr,
  input logic                     out_valid,
  input logic                     out_hit,
  input logic [CNT_W-1:0]         out_count,
  input logic [N_INSN*INSN_W-1:0] out_insns,
  input logic [ADDR_W-1:0]        out_next,
  input logic                     wr_en,
  input logic [CNT_W-1:0]         wr_cnt,
  input logic [M_BLK-1:0]         wr_mask
);

  logic tail_ok;
  always_comb begin
    tail_ok = 1'b1;
    for (int i = 0; i < N_INSN; i++) begin
      if ((CNT_W'(i) >= out_count) && (out_insns[i*INSN_W +: INSN_W] != '0)) tail_ok = 1'b0;
    end
  end

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> out_valid);
  p_idle_follows_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !out_valid);
  p_miss_single_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_hit) |-> (out_count == CNT_W'(1)));
  p_miss_next_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_hit) |-> (out_next == $past(lk_addr) + 1'b1));
  p_hit_count_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_hit) |-> ((out_count != '0) && (out_count <= CNT_W'(N_INSN))));
  p_tail_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> tail_ok);
  p_fill_size_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> ((wr_cnt != '0) && (wr_cnt <= CNT_W'(N_INSN))));
  p_fill_mask_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (((wr_mask + 1'b1) & wr_mask) == '0));

endmodule

bind trace_cache_fetch tc_checker #(
  .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BLK(M_BLK)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_count(out_count),
  .out_insns(out_insns), .out_next(out_next),
  .wr_en(wr_en), .wr_cnt(wr_cnt), .wr_mask(wr_mask)
);

// File: tb/sim_trace_cache_fetch.sv
module sim_trace_cache_fetch;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         lk_valid;
  logic [15:0]  lk_addr;
  logic [2:0]   lk_pred;
  logic [15:0]  ic_insn;
  logic         fl_valid;
  logic [15:0]  fl_pc;
  logic [15:0]  fl_insn;
  logic         fl_is_br;
  logic         fl_taken;
  logic [15:0]  fl_target;
  logic         out_valid;
  logic         out_hit;
  logic [3:0]   out_count;
  logic [127:0] out_insns;
  logic [15:0]  out_next;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [127:0] exp_a, exp_b, exp_f;

  always #5 clk = ~clk;

  trace_cache_fetch u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_pred(lk_pred), .ic_insn(ic_insn), .fl_valid(fl_valid), .fl_pc(fl_pc),
    .fl_insn(fl_insn), .fl_is_br(fl_is_br), .fl_taken(fl_taken),
    .fl_target(fl_target), .out_valid(out_valid), .out_hit(out_hit),
    .out_count(out_count), .out_insns(out_insns), .out_next(out_next)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_addr = 0; lk_pred = 0; ic_insn = 0;
    fl_valid = 0; fl_pc = 0; fl_insn = 0; fl_is_br = 0; fl_taken = 0; fl_target = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic lookup(logic [15:0] a, logic [2:0] p, logic [15:0] ic);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_pred = p; ic_insn = ic;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(logic [15:0] pc, logic [15:0] insn, logic br, logic tk, logic [15:0] tgt);
    @(negedge clk);
    fl_valid = 1; fl_pc = pc; fl_insn = insn; fl_is_br = br; fl_taken = tk; fl_target = tgt;
    @(negedge clk);
    fl_valid = 0; fl_is_br = 0;
  endtask

  task automatic expect_hit(string req, logic [3:0] cnt, logic [127:0] ins, logic [15:0] nxt);
    check({req, " hit"}, 128'(out_hit), 128'(1));
    check({req, " count"}, 128'(out_count), 128'(cnt));
    check({req, " insns"}, out_insns, ins);
    check({req, " next"}, 128'(out_next), 128'(nxt));
  endtask

  task automatic expect_miss(string req, logic [15:0] a, logic [15:0] ic);
    check({req, " hit"}, 128'(out_hit), 128'(0));
    check({req, " R6 count"}, 128'(out_count), 128'(1));
    check({req, " R6 slot0"}, 128'(out_insns[15:0]), 128'(ic));
    check({req, " R11 tail"}, 128'(out_insns[127:16]), 128'(0));
    check({req, " R6 next"}, 128'(out_next), 128'(a + 16'd1));
  endtask

  task automatic t_reset_miss();
    lookup(16'h0040, 3'b101, 16'h5555);
    check("R12 out_valid", 128'(out_valid), 128'(1));
    expect_miss("R1 after reset", 16'h0040, 16'h5555);
  endtask

  // R8: third branch closes trace A in set 0; directions b0=1 b1=0 b2=1
  task automatic t_fill_branch_limit();
    exp_a = '0;
    exp_a[0*16 +: 16] = 16'hA000; fill(16'h0040, 16'hA000, 0, 0, 16'h0);
    exp_a[1*16 +: 16] = 16'hA001; fill(16'h0041, 16'hA001, 1, 1, 16'h0080);
    exp_a[2*16 +: 16] = 16'hA002; fill(16'h0080, 16'hA002, 0, 0, 16'h0);
    exp_a[3*16 +: 16] = 16'hA003; fill(16'h0081, 16'hA003, 1, 0, 16'h0090);
    exp_a[4*16 +: 16] = 16'hA004; fill(16'h0082, 16'hA004, 1, 1, 16'h00A0);
    lookup(16'h0040, 3'b101, 16'h1111);
    expect_hit("R8 R2 R9 trace A taken", 4'd5, exp_a, 16'h00A0);
  endtask

  task automatic t_pred_mismatch();
    lookup(16'h0040, 3'b100, 16'h2222);
    expect_miss("R4 pred b0 differs", 16'h0040, 16'h2222);
    lookup(16'h0040, 3'b001, 16'h2323);
    expect_miss("R4 pred b2 differs", 16'h0040, 16'h2323);
  endtask

  task automatic t_tag_mismatch();
    lookup(16'h0140, 3'b101, 16'h3333);
    expect_miss("R5 other tag", 16'h0140, 16'h3333);
  endtask

  // R7: eight instructions, one not-taken branch at slot 1, set 1
  task automatic t_fill_insn_limit();
    exp_b = '0;
    for (int k = 0; k < 8; k++) begin
      exp_b[k*16 +: 16] = 16'hB000 + 16'(k);
      fill(16'h0051 + 16'(k), 16'hB000 + 16'(k), (k == 1), 1'b0, 16'h0070);
    end
    lookup(16'h0051, 3'b110, 16'h4444);
    expect_hit("R7 R3 trace B unmasked bits ignored", 4'd8, exp_b, 16'h0059);
    lookup(16'h0051, 3'b000, 16'h4445);
    expect_hit("R3 trace B zero preds", 4'd8, exp_b, 16'h0059);
    lookup(16'h0051, 3'b111, 16'h4446);
    expect_miss("R4 trace B masked bit differs", 16'h0051, 16'h4446);
  endtask

  // R9: three not-taken branches, next is fall-through
  task automatic t_fallthrough();
    logic [127:0] e = '0;
    e[0*16 +: 16] = 16'hD000; fill(16'h0073, 16'hD000, 1, 0, 16'h0010);
    e[1*16 +: 16] = 16'hD001; fill(16'h0074, 16'hD001, 1, 0, 16'h0020);
    e[2*16 +: 16] = 16'hD002; fill(16'h0075, 16'hD002, 1, 0, 16'h0200);
    lookup(16'h0073, 3'b000, 16'h6666);
    expect_hit("R9 R11 trace D not taken", 4'd3, e, 16'h0076);
  endtask

  // R9: no branches in line, any prediction, next is fall-through
  task automatic t_no_branch();
    logic [127:0] e = '0;
    for (int k = 0; k < 8; k++) begin
      e[k*16 +: 16] = 16'hE000 + 16'(k);
      fill(16'h0084 + 16'(k), 16'hE000 + 16'(k), 1'b0, 1'b0, 16'h0);
    end
    lookup(16'h0084, 3'b111, 16'h7777);
    expect_hit("R9 R3 trace E no branches", 4'd8, e, 16'h008C);
  endtask

  // R10: write to set 0 in the same cycle as a lookup of set 0
  task automatic t_same_cycle();
    exp_f = '0;
    exp_f[0*16 +: 16] = 16'hF000; fill(16'h0048, 16'hF000, 1, 0, 16'h0001);
    exp_f[1*16 +: 16] = 16'hF001; fill(16'h0049, 16'hF001, 1, 0, 16'h0002);
    exp_f[2*16 +: 16] = 16'hF002;
    @(negedge clk);
    fl_valid = 1; fl_pc = 16'h004A; fl_insn = 16'hF002; fl_is_br = 1; fl_taken = 1;
    fl_target = 16'h0400;
    lk_valid = 1; lk_addr = 16'h0040; lk_pred = 3'b101; ic_insn = 16'h8888;
    @(negedge clk);
    fl_valid = 0; fl_is_br = 0; lk_valid = 0;
    expect_hit("R10 old line seen", 4'd5, exp_a, 16'h00A0);
    lookup(16'h0040, 3'b101, 16'h8889);
    expect_miss("R10 old line replaced", 16'h0040, 16'h8889);
    lookup(16'h0048, 3'b100, 16'h888A);
    expect_hit("R10 R9 new line", 4'd3, exp_f, 16'h0400);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R12 idle", 128'(out_valid), 128'(0));
  endtask

  task automatic t_rereset();
    apply_reset();
    lookup(16'h0048, 3'b100, 16'h9999);
    expect_miss("R1 lines cleared", 16'h0048, 16'h9999);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    apply_reset();
    t_reset_miss();
    t_fill_branch_limit();
    t_pred_mismatch();
    t_tag_mismatch();
    t_fill_insn_limit();
    t_fallthrough();
    t_no_branch();
    t_same_cycle();
    t_idle();
    t_rereset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule